// File: doc/BRIEF.md
# Predicate Register File with Compare

This block keeps a bank of single-bit predicates that guard instruction commit. An equality compare writes two predicates at once: the first destination takes the equality result and the second takes its inverse. Each instruction slot of an issue group presents a guard index and a valid flag. The block answers with a commit enable. The enable is high only when the slot is valid and the selected predicate is 1. When the enable is low, the slot's result is thrown away.

A pair of complementary predicates lets both arms of an if/else sit in one issue group with no branch. The compare itself is reduced to a one-bit equality flag computed elsewhere. Guard index 0 is fixed at 1, so unguarded instructions always commit. Predicate writes take effect at the clock edge. A read in the same cycle as a write returns the stored value from before the write.

Top module: `pred_regfile`

## Requirements
- R1: After reset every predicate reads 0, except index 0.
- R2: Index 0 always reads 1. A compare that names index 0 as either destination leaves it at 1.
- R3: A valid compare stores its equality flag (1 = equal) into the predicate named by its first destination index.
- R4: A valid compare stores the inverse of its equality flag into the predicate named by its second destination index.
- R5: When both destination indices of a compare are the same, that predicate takes the first-destination value, which is the equality flag.
- R6: A guard read in the same cycle as a compare that writes the same predicate returns the old value. The new value is seen from the next cycle on.
- R7: Slot s has commit_en[s] = 1 exactly when slot_valid[s] is 1 and the predicate selected by guard index field s reads 1. Field s occupies bits [s*IDX_W +: IDX_W] of qual_idx.
- R8: In a cycle with cmp_valid low, no predicate changes.
- R9: Slots are evaluated independently. Several slots may select the same index, or complementary indices, in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | A compare result is to be written this cycle |
| cmp_dst_a | input | IDX_W | Destination index that receives the equality flag |
| cmp_dst_b | input | IDX_W | Destination index that receives the inverted flag |
| cmp_equal | input | 1 | Equality outcome of the compare (1 = equal) |
| slot_valid | input | NUM_SLOTS | An instruction is present in each slot |
| qual_idx | input | NUM_SLOTS*IDX_W | Guard predicate index for each slot, packed per slot |
| commit_en | output | NUM_SLOTS | Commit enable for each slot |

## Verification
A compare write and guard reads of the same predicates often land in the same cycle. This happens when a compare feeds an instruction in the very next group, and when one compare has both destinations named by guards. The bench builds these collisions deliberately: directed steps read a predicate while it is being overwritten, and a long pseudo-random phase draws indices from a small pool so that collisions are frequent. A bit-level reference model holds the old value through the write cycle and applies the update afterwards. Every slot's enable is compared with this model on every cycle, which judges whether the write became visible exactly one cycle later.

// File: rtl/pred_pkg.sv
package pred_pkg;
    localparam int unsigned PRED_COUNT_DEFAULT = 64;
    localparam int unsigned SLOT_COUNT_DEFAULT = 3;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/pred_cmp_update.sv
module pred_cmp_update #(
    parameter int unsigned NUM_PREDS = pred_pkg::PRED_COUNT_DEFAULT,
    localparam int unsigned IDX_W = pred_pkg::idx_width(NUM_PREDS)
) (
    input  logic [NUM_PREDS-1:0] cur,
    input  logic                 cmp_valid,
    input  logic [IDX_W-1:0]     cmp_dst_a,
    input  logic [IDX_W-1:0]     cmp_dst_b,
    input  logic                 cmp_equal,
    output logic [NUM_PREDS-1:0] nxt
);
    // Index 0 is a constant true guard; every other bit follows the compare.
    assign nxt[0] = 1'b1;

    for (genvar i = 1; i < NUM_PREDS; i++) begin : g_bit
        always_comb begin
            nxt[i] = cur[i];
            if (cmp_valid) begin
                if (cmp_dst_a == IDX_W'(i)) begin
                    nxt[i] = cmp_equal;
                end else if (cmp_dst_b == IDX_W'(i)) begin
                    nxt[i] = ~cmp_equal;
                end
            end
        end
    end
endmodule

// File: rtl/pred_read_port.sv
module pred_read_port #(
    parameter int unsigned NUM_PREDS = pred_pkg::PRED_COUNT_DEFAULT,
    localparam int unsigned IDX_W = pred_pkg::idx_width(NUM_PREDS)
) (
    input  logic [NUM_PREDS-1:0] preds,
    input  logic [IDX_W-1:0]     idx,
    input  logic                 valid,
    output logic                 enable
);
    logic sel_bit;

    always_comb begin
        sel_bit = 1'b0;
        if (32'(idx) < NUM_PREDS) begin
            sel_bit = preds[idx];
        end
        enable = valid & sel_bit;
    end
endmodule

// File: rtl/pred_regfile.sv
module pred_regfile #(
    parameter int unsigned NUM_PREDS = pred_pkg::PRED_COUNT_DEFAULT,
    parameter int unsigned NUM_SLOTS = pred_pkg::SLOT_COUNT_DEFAULT,
    localparam int unsigned IDX_W = pred_pkg::idx_width(NUM_PREDS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmp_valid,
    input  logic [IDX_W-1:0]           cmp_dst_a,
    input  logic [IDX_W-1:0]           cmp_dst_b,
    input  logic                       cmp_equal,
    input  logic [NUM_SLOTS-1:0]       slot_valid,
    input  logic [NUM_SLOTS*IDX_W-1:0] qual_idx,
    output logic [NUM_SLOTS-1:0]       commit_en
);
    typedef struct packed {
        logic [NUM_PREDS-1:0] pred;
    } state_t;

    localparam logic [NUM_PREDS-1:0] RESET_PREDS = NUM_PREDS'(1);

    state_t state_d, state_q;
    logic [NUM_PREDS-1:0] upd_nxt;
    logic [NUM_PREDS-1:0] pred_q;

    assign pred_q = state_q.pred;

    pred_cmp_update #(.NUM_PREDS(NUM_PREDS)) u_update (
        .cur       (state_q.pred),
        .cmp_valid (cmp_valid),
        .cmp_dst_a (cmp_dst_a),
        .cmp_dst_b (cmp_dst_b),
        .cmp_equal (cmp_equal),
        .nxt       (upd_nxt)
    );

    // Reads use the registered bank, so a write lands one cycle later.
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        pred_read_port #(.NUM_PREDS(NUM_PREDS)) u_read (
            .preds  (state_q.pred),
            .idx    (qual_idx[s*IDX_W +: IDX_W]),
            .valid  (slot_valid[s]),
            .enable (commit_en[s])
        );
    end

    always_comb begin
        state_d = state_q;
        state_d.pred = upd_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.pred <= RESET_PREDS;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/pred_regfile_chk.sv
module pred_regfile_chk #(
    parameter int unsigned NUM_PREDS = 64,
    parameter int unsigned NUM_SLOTS = 3,
    localparam int unsigned IDX_W = pred_pkg::idx_width(NUM_PREDS)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cmp_valid,
    input logic [IDX_W-1:0]           cmp_dst_a,
    input logic [IDX_W-1:0]           cmp_dst_b,
    input logic                       cmp_equal,
    input logic [NUM_SLOTS-1:0]       slot_valid,
    input logic [NUM_SLOTS*IDX_W-1:0] qual_idx,
    input logic [NUM_SLOTS-1:0]       commit_en,
    input logic [NUM_PREDS-1:0]       pred_q
);
    a_r2_zero_held: assert property (@(posedge clk) disable iff (!rst_n)
        pred_q[0] == 1'b1);

    a_r3_first_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_dst_a != '0)
        |=> pred_q[$past(cmp_dst_a)] == $past(cmp_equal));

    a_r4_second_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_dst_b != '0 && cmp_dst_b != cmp_dst_a)
        |=> pred_q[$past(cmp_dst_b)] == !$past(cmp_equal));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |=> $stable(pred_q));

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        a_r7_idle_slot: assert property (@(posedge clk) disable iff (!rst_n)
            !slot_valid[s] |-> !commit_en[s]);
        a_r2_zero_commits: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_valid[s] && qual_idx[s*IDX_W +: IDX_W] == '0) |-> commit_en[s]);
    end
endmodule

bind pred_regfile pred_regfile_chk #(.NUM_PREDS(NUM_PREDS), .NUM_SLOTS(NUM_SLOTS)) u_chk (.*);

// File: tb/pred_regfile_test.sv
module pred_regfile_test;
    localparam int NP = 64;
    localparam int NS = 3;
    localparam int IW = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmp_valid = 1'b0;
    logic [IW-1:0]   cmp_dst_a = '0;
    logic [IW-1:0]   cmp_dst_b = '0;
    logic            cmp_equal = 1'b0;
    logic [NS-1:0]   slot_valid = '0;
    logic [NS*IW-1:0] qual_idx = '0;
    logic [NS-1:0]   commit_en;

    int checks = 0;
    int errors = 0;
    bit model [NP];

    always #2 clk = ~clk;

    pred_regfile uut (.*);

    function automatic string tag_for(int s);
        int q = int'(qual_idx[s*IW +: IW]);
        if (!rst_n) return "R1";
        if (!slot_valid[s]) return "R7";
        if (q == 0) return "R2";
        if (cmp_valid && (q == int'(cmp_dst_a) || q == int'(cmp_dst_b))) return "R6";
        return "R9";
    endfunction

    task automatic check_slots(string why);
        for (int s = 0; s < NS; s++) begin
            int q = int'(qual_idx[s*IW +: IW]);
            bit exp = slot_valid[s] && model[q];
            checks++;
            if (commit_en[s] !== exp) begin
                errors++;
                $display("FAIL %s/%s slot %0d idx %0d: got %b expected %b",
                         why, tag_for(s), s, q, commit_en[s], exp);
            end
        end
    endtask

    // Apply inputs after a falling edge, check before the rising edge,
    // then advance the model as the design does at that edge.
    task automatic step(bit cv, int a, int b, bit eq, bit [NS-1:0] sv,
                        int q0, int q1, int q2, string why);
        @(negedge clk);
        cmp_valid = cv; cmp_dst_a = IW'(a); cmp_dst_b = IW'(b); cmp_equal = eq;
        slot_valid = sv;
        qual_idx = {IW'(q2), IW'(q1), IW'(q0)};
        #1;
        check_slots(why);
        if (rst_n && cv) begin
            if (b != 0) model[b] = !eq;
            if (a != 0) model[a] = eq;
        end
    endtask

    task automatic sweep(string why);
        for (int i = 0; i < NP; i += NS)
            step(0, 0, 0, 0, '1, i, (i + 1) % NP, (i + 2) % NP, why);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NP; i++) model[i] = (i == 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        sweep("R1 reset state");
        // R2: writes aimed at index 0 are dropped
        step(1, 0, 0, 0, '0, 0, 0, 0, "R2 write zero");
        step(1, 5, 0, 1, 3'b111, 0, 5, 0, "R2 zero as second dest");
        step(0, 0, 0, 0, 3'b111, 0, 5, 0, "R2 zero unchanged");
        // R3/R4: pair write, then read both
        step(1, 7, 8, 1, '0, 0, 0, 0, "R3 R4 pair equal");
        step(0, 0, 0, 0, 3'b111, 7, 8, 0, "R3 R4 readback");
        step(1, 7, 8, 0, 3'b111, 7, 8, 7, "R6 read during overwrite");
        step(0, 0, 0, 0, 3'b111, 7, 8, 7, "R6 visible next cycle");
        // R5: same destination twice
        step(1, 9, 9, 1, '0, 0, 0, 0, "R5 same dest equal");
        step(1, 10, 10, 0, 3'b111, 9, 9, 9, "R5 same dest result");
        step(0, 0, 0, 0, 3'b111, 10, 9, 0, "R5 not-equal result");
        // R7: invalid slots never commit
        step(0, 0, 0, 0, 3'b010, 0, 0, 8, "R7 invalid slot");
        // R8: idle compare with changing guards
        step(0, 63, 62, 1, 3'b111, 63, 62, 7, "R8 idle");
        step(0, 0, 0, 0, 3'b111, 63, 62, 7, "R8 unchanged");
        // R9 and R6: collision-heavy random traffic on a small index pool
        for (int n = 0; n < 3000; n++) begin
            int pool = (n < 1500) ? 6 : NP;
            step(bit'($urandom % 2), int'($urandom % pool), int'($urandom % pool),
                 bit'($urandom % 2), NS'($urandom),
                 int'($urandom % pool), int'($urandom % pool), int'($urandom % pool),
                 "R9 random");
        end
        sweep("R3 final state");
        // R1 again: reset in the middle of traffic
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NP; i++) model[i] = (i == 0);
        sweep("R1 second reset");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule